// File: doc/BRIEF.md
# Pipelined FPU Issue Dispatcher

This block sits between an instruction decoder and a pipelined floating-point unit. Each cycle it decides whether the decoded floating-point operation on its inputs may be sent to the unit. It keeps a small scoreboard of operations already in flight. Each entry holds the destination register and a countdown to the cycle in which that result is due. Issue is held back only for real reasons: a data dependence on an outstanding result, two results due at the single writeback port in the same cycle, a full scoreboard, or a long-latency operation that must run alone. Independent operations therefore enter a deep pipeline one per cycle. Only the serializing latency class forces one operation at a time.

The same scoreboard gives integer-side hazard flags. A non-floating-point instruction can keep executing while floating-point work is outstanding, unless it reads or overwrites a register that an outstanding operation will write. A flush input drops every pending entry. The unit is expected to flush its own pipeline at the same time.

Fixed-latency classes are assumed to return their result-valid pulse exactly on time. The serializing class returns whenever the unit finishes.

Top module: `fpu_issue_sched`

## Requirements
- R1: A synchronous reset empties the scoreboard. Right after reset no hazard flag is raised, and a valid operation issues at once.
- R2: The latency class encoding is 2'b00 = 1 cycle, 2'b01 = ADDMUL_LAT cycles, 2'b10 = OTHER_LAT cycles, 2'b11 = serializing. A fixed-class result is due in the cycle that lies its latency after the issue cycle. Its entry retires when the result-valid pulse is seen in that cycle.
- R3: Independent operations of classes 2'b00, 2'b01 and 2'b10 issue one per cycle with no bubble, as long as the class latency does not exceed NUM_ENTRIES.
- R4: An operation stalls while any of its three source registers equals the destination of an outstanding entry, including an entry that retires in the current cycle.
- R5: An operation stalls while its destination equals the destination of an outstanding entry, including one that retires in the current cycle.
- R6: A fixed-class operation stalls if its result would fall due in the same cycle as that of an outstanding fixed-class entry.
- R7: A serializing operation issues only in a cycle in which the scoreboard holds no entry.
- R8: While a serializing entry is outstanding, nothing issues, including in the cycle of its result-valid pulse. Issue resumes in the following cycle.
- R9: With every entry occupied, issue stalls even without a data hazard. An entry that retires in the current cycle counts as free.
- R10: A flush drops every pending entry and blocks issue in its own cycle. From the next cycle on, the dropped entries cause no hazard.
- R11: The integer read-hazard flag is high while either integer source equals an outstanding destination. The integer write-hazard flag is high while the integer destination equals one. Both flags are independent of the floating-point issue.
- R12: The stall output is high exactly when a valid operation is present and not issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| flush_i | input | 1 | Drop all pending entries, block issue this cycle |
| op_valid_i | input | 1 | A decoded floating-point operation is present |
| op_class_i | input | 2 | Latency class of the operation |
| op_rs1_i | input | REG_W | First source register |
| op_rs2_i | input | REG_W | Second source register |
| op_rs3_i | input | REG_W | Third source register |
| op_rd_i | input | REG_W | Destination register |
| fpu_res_valid_i | input | 1 | Result-valid pulse from the floating-point unit |
| int_rs1_i | input | REG_W | First source of the current non-floating-point instruction |
| int_rs2_i | input | REG_W | Second source of the current non-floating-point instruction |
| int_rd_i | input | REG_W | Destination of the current non-floating-point instruction |
| issue_o | output | 1 | The operation is sent to the unit this cycle |
| stall_o | output | 1 | A valid operation is held back this cycle |
| int_raw_o | output | 1 | Integer source matches an outstanding destination |
| int_waw_o | output | 1 | Integer destination matches an outstanding destination |

## Verification
A wrong internal state shows up at the ports within a cycle, either as a stall that should not happen or as an issue that should not. An entry that stays after its result returns keeps a dependent operation stalled one cycle too long. It also keeps an integer hazard flag raised after the retirement cycle. A lost entry lets a dependent operation issue early. A countdown that is off by one changes the stall length of a dependent operation by exactly one cycle. It also moves the cycle in which a writeback collision stalls. The bench therefore counts stall cycles for each class and checks the exact cycle in which issue resumes after a full scoreboard, a serializing pulse and a flush.

// File: rtl/fpis_pkg.sv
package fpis_pkg;

   // Latency class of a decoded operation; the encoding is decoded by the dispatcher
   typedef enum logic [1:0] {
      LC_SINGLE = 2'b00,
      LC_ADDMUL = 2'b01,
      LC_OTHER  = 2'b10,
      LC_SERIAL = 2'b11
   } lat_class_e;

   localparam int unsigned NUM_SRC = 3;

endpackage

// File: rtl/fpis_lat_map.sv
module fpis_lat_map
   import fpis_pkg::*;
#(
   parameter int unsigned ADDMUL_LAT = 3,
   parameter int unsigned OTHER_LAT  = 5,
   parameter int unsigned CNT_W      = 3
) (
   input  lat_class_e       cls_i,
   output logic [CNT_W-1:0] lat_o,
   output logic             serial_o
);

   always_comb begin
      serial_o = 1'b0;
      unique case (cls_i)
         LC_SINGLE: lat_o = CNT_W'(1);
         LC_ADDMUL: lat_o = CNT_W'(ADDMUL_LAT);
         LC_OTHER:  lat_o = CNT_W'(OTHER_LAT);
         default: begin
            // serializing work is tracked as due at once and waits for the pulse
            lat_o    = CNT_W'(1);
            serial_o = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/fpis_pick.sv
module fpis_pick #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o,
   output logic         any_o
);

   logic [N:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt_o[i]  = req_i[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req_i[i];
   end

   assign any_o = seen[N];

endmodule

// File: rtl/fpis_slot.sv
module fpis_slot
   import fpis_pkg::*;
#(
   parameter int unsigned REG_W = 5,
   parameter int unsigned CNT_W = 3
) (
   input  logic                            clk_i,
   input  logic                            rst_i,
   input  logic                            flush_i,
   input  logic                            alloc_i,
   input  logic                            retire_i,
   input  logic                            issue_i,
   input  logic [NUM_SRC-1:0][REG_W-1:0]   op_src_i,
   input  logic [REG_W-1:0]                op_rd_i,
   input  logic [CNT_W-1:0]                op_lat_i,
   input  logic                            op_serial_i,
   input  logic [REG_W-1:0]                int_rs1_i,
   input  logic [REG_W-1:0]                int_rs2_i,
   input  logic [REG_W-1:0]                int_rd_i,
   output logic                            valid_o,
   output logic                            serial_o,
   output logic                            due_o,
   output logic                            raw_o,
   output logic                            waw_o,
   output logic                            clash_o,
   output logic                            int_raw_o,
   output logic                            int_waw_o
);

   logic               valid_q;
   logic               serial_q;
   logic [REG_W-1:0]   rd_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [NUM_SRC-1:0] src_hit;
   logic [CNT_W:0]     lat_plus;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign src_hit[s] = (op_src_i[s] == rd_q);
   end

   assign lat_plus  = {1'b0, op_lat_i} + {{CNT_W{1'b0}}, 1'b1};

   assign valid_o   = valid_q;
   assign serial_o  = valid_q & serial_q;
   assign due_o     = valid_q & (cnt_q == CNT_W'(1));
   assign raw_o     = valid_q & (|src_hit);
   assign waw_o     = valid_q & (op_rd_i == rd_q);
   assign clash_o   = valid_q & ~serial_q & ({1'b0, cnt_q} == lat_plus);
   assign int_raw_o = valid_q & ((int_rs1_i == rd_q) | (int_rs2_i == rd_q));
   assign int_waw_o = valid_q & (int_rd_i == rd_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         valid_q  <= 1'b0;
         serial_q <= 1'b0;
         rd_q     <= '0;
         cnt_q    <= '0;
      end else if (alloc_i) begin
         valid_q  <= 1'b1;
         serial_q <= op_serial_i;
         rd_q     <= op_rd_i;
         cnt_q    <= op_lat_i;
      end else if (flush_i || retire_i) begin
         valid_q  <= 1'b0;
      end else if (valid_q && (cnt_q > CNT_W'(1))) begin
         cnt_q    <= cnt_q - CNT_W'(1);
      end
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk_i) rst_i |=> !valid_q);

   // R4
   raw_block_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !(valid_q && issue_i && (|src_hit)));

   // R5
   waw_block_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !(valid_q && issue_i && (op_rd_i == rd_q)));

   // R10
   flush_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      flush_i |=> !valid_q);

endmodule

// File: rtl/fpu_issue_sched.sv
module fpu_issue_sched
   import fpis_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned REG_W       = 5,
   parameter int unsigned ADDMUL_LAT  = 3,
   parameter int unsigned OTHER_LAT   = 5
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             flush_i,
   input  logic             op_valid_i,
   input  logic [1:0]       op_class_i,
   input  logic [REG_W-1:0] op_rs1_i,
   input  logic [REG_W-1:0] op_rs2_i,
   input  logic [REG_W-1:0] op_rs3_i,
   input  logic [REG_W-1:0] op_rd_i,
   input  logic             fpu_res_valid_i,
   input  logic [REG_W-1:0] int_rs1_i,
   input  logic [REG_W-1:0] int_rs2_i,
   input  logic [REG_W-1:0] int_rd_i,
   output logic             issue_o,
   output logic             stall_o,
   output logic             int_raw_o,
   output logic             int_waw_o
);

   localparam int unsigned MAX_LAT = (ADDMUL_LAT > OTHER_LAT) ? ADDMUL_LAT : OTHER_LAT;
   localparam int unsigned CNT_W   = $clog2(MAX_LAT + 2);

   // elaboration-time parameter checks
   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("fpu_issue_sched: NUM_ENTRIES must be at least 2");
   end
   if (REG_W < 1) begin : g_bad_regw
      $error("fpu_issue_sched: REG_W must be at least 1");
   end
   if (ADDMUL_LAT < 1) begin : g_bad_addmul
      $error("fpu_issue_sched: ADDMUL_LAT must be at least 1");
   end
   if (OTHER_LAT < 1) begin : g_bad_other
      $error("fpu_issue_sched: OTHER_LAT must be at least 1");
   end

   lat_class_e                    cls;
   logic [CNT_W-1:0]              new_lat;
   logic                          new_serial;
   logic [NUM_SRC-1:0][REG_W-1:0] srcs;

   logic [NUM_ENTRIES-1:0] valid_vec;
   logic [NUM_ENTRIES-1:0] serial_vec;
   logic [NUM_ENTRIES-1:0] due_vec;
   logic [NUM_ENTRIES-1:0] raw_vec;
   logic [NUM_ENTRIES-1:0] waw_vec;
   logic [NUM_ENTRIES-1:0] clash_vec;
   logic [NUM_ENTRIES-1:0] iraw_vec;
   logic [NUM_ENTRIES-1:0] iwaw_vec;
   logic [NUM_ENTRIES-1:0] due_first;
   logic [NUM_ENTRIES-1:0] retire_vec;
   logic [NUM_ENTRIES-1:0] free_vec;
   logic [NUM_ENTRIES-1:0] free_first;
   logic [NUM_ENTRIES-1:0] alloc_vec;
   logic                   due_any;
   logic                   free_any;
   logic                   any_valid;
   logic                   serial_busy;
   logic                   data_hazard;
   logic                   slot_ok;

   assign cls     = lat_class_e'(op_class_i);
   assign srcs[0] = op_rs1_i;
   assign srcs[1] = op_rs2_i;
   assign srcs[2] = op_rs3_i;

   fpis_lat_map #(
      .ADDMUL_LAT (ADDMUL_LAT),
      .OTHER_LAT  (OTHER_LAT),
      .CNT_W      (CNT_W)
   ) u_lat_map (
      .cls_i    (cls),
      .lat_o    (new_lat),
      .serial_o (new_serial)
   );

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
      fpis_slot #(
         .REG_W (REG_W),
         .CNT_W (CNT_W)
      ) u_slot (
         .clk_i       (clk_i),
         .rst_i       (rst_i),
         .flush_i     (flush_i),
         .alloc_i     (alloc_vec[i]),
         .retire_i    (retire_vec[i]),
         .issue_i     (issue_o),
         .op_src_i    (srcs),
         .op_rd_i     (op_rd_i),
         .op_lat_i    (new_lat),
         .op_serial_i (new_serial),
         .int_rs1_i   (int_rs1_i),
         .int_rs2_i   (int_rs2_i),
         .int_rd_i    (int_rd_i),
         .valid_o     (valid_vec[i]),
         .serial_o    (serial_vec[i]),
         .due_o       (due_vec[i]),
         .raw_o       (raw_vec[i]),
         .waw_o       (waw_vec[i]),
         .clash_o     (clash_vec[i]),
         .int_raw_o   (iraw_vec[i]),
         .int_waw_o   (iwaw_vec[i])
      );
   end

   // one returning result retires the lowest due entry
   fpis_pick #(.N(NUM_ENTRIES)) u_retire_pick (
      .req_i (due_vec),
      .gnt_o (due_first),
      .any_o (due_any)
   );

   assign retire_vec = due_first & {NUM_ENTRIES{fpu_res_valid_i & due_any}};
   assign free_vec   = ~valid_vec | retire_vec;

   fpis_pick #(.N(NUM_ENTRIES)) u_free_pick (
      .req_i (free_vec),
      .gnt_o (free_first),
      .any_o (free_any)
   );

   assign any_valid   = |valid_vec;
   assign serial_busy = |serial_vec;
   assign data_hazard = (|raw_vec) | (|waw_vec);
   assign slot_ok     = new_serial ? ~any_valid : (free_any & ~(|clash_vec));

   assign issue_o   = op_valid_i & ~flush_i & ~data_hazard & ~serial_busy & slot_ok;
   assign stall_o   = op_valid_i & ~issue_o;
   assign alloc_vec = free_first & {NUM_ENTRIES{issue_o}};
   assign int_raw_o = |iraw_vec;
   assign int_waw_o = |iwaw_vec;

   // R6
   wb_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(due_vec));

   // R9
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      issue_o |-> ($countones(alloc_vec) == 1));

   // R8
   serial_alone_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      serial_busy |-> !issue_o);

   // R7
   serial_empty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (issue_o && new_serial) |=> ($countones(valid_vec) == 1));

endmodule

// File: tb/fpu_issue_sched_tb.sv
module fpu_issue_sched_tb;

   localparam int ENTRIES = 4;
   localparam int RW      = 5;
   localparam int LAT_AM  = 3;
   localparam int LAT_OT  = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          flush = 1'b0;
   logic          op_valid = 1'b0;
   logic [1:0]    op_class = 2'b00;
   logic [RW-1:0] rs1 = 5'd28, rs2 = 5'd29, rs3 = 5'd30, rd = 5'd31;
   logic          man_res = 1'b0;
   logic          res_valid;
   logic [RW-1:0] irs1 = 5'd27, irs2 = 5'd27, ird = 5'd27;
   logic          issue, stall, iraw, iwaw;

   bit   [63:0]   pend = '0;
   logic [31:0]   cyc  = '0;
   int            n_chk = 0;
   int            n_err = 0;

   always #10 clk = ~clk;   // 50 MHz

   fpu_issue_sched #(
      .NUM_ENTRIES (ENTRIES),
      .REG_W       (RW),
      .ADDMUL_LAT  (LAT_AM),
      .OTHER_LAT   (LAT_OT)
   ) u_dut (
      .clk_i           (clk),
      .rst_i           (rst),
      .flush_i         (flush),
      .op_valid_i      (op_valid),
      .op_class_i      (op_class),
      .op_rs1_i        (rs1),
      .op_rs2_i        (rs2),
      .op_rs3_i        (rs3),
      .op_rd_i         (rd),
      .fpu_res_valid_i (res_valid),
      .int_rs1_i       (irs1),
      .int_rs2_i       (irs2),
      .int_rd_i        (ird),
      .issue_o         (issue),
      .stall_o         (stall),
      .int_raw_o       (iraw),
      .int_waw_o       (iwaw)
   );

   // Model of a fixed-latency FPU: a result-valid pulse comes back the class latency after issue
   function automatic int lat_of(input logic [1:0] c);
      case (c)
         2'b00:   return 1;
         2'b01:   return LAT_AM;
         2'b10:   return LAT_OT;
         default: return 0;
      endcase
   endfunction

   assign res_valid = pend[cyc[5:0]] | man_res;

   always @(posedge clk) begin
      if (rst || flush) begin
         pend <= '0;
      end else begin
         pend[cyc[5:0]] <= 1'b0;
         if (issue && op_class != 2'b11)
            pend[6'(cyc + 32'(lat_of(op_class)))] <= 1'b1;
      end
      cyc <= cyc + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_op(input logic v, input logic [1:0] c, input logic [RW-1:0] a,
                         input logic [RW-1:0] b, input logic [RW-1:0] d3, input logic [RW-1:0] d);
      op_valid = v; op_class = c; rs1 = a; rs2 = b; rs3 = d3; rd = d;
   endtask

   task automatic idle(input int n);
      op_valid = 1'b0;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // counts stall cycles from the current cycle until the held operation issues
   task automatic count_stalls(output int n);
      n = 0;
      for (int i = 0; i < 40; i++) begin
         #1;
         if (issue) return;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      #1;
      check("R1 issue idle", int'(issue), 0);
      check("R12 stall idle", int'(stall), 0);
      irs1 = 5'd0; irs2 = 5'd0; ird = 5'd0;
      #1;
      check("R1 int_raw after reset", int'(iraw), 0);
      check("R1 int_waw after reset", int'(iwaw), 0);
      irs1 = 5'd27; irs2 = 5'd27; ird = 5'd27;
      set_op(1, 2'b10, 28, 29, 30, 5);
      #1;
      check("R1 first op issues", int'(issue), 1);
      @(negedge clk);
      op_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      irs1 = 5'd5;
      #1;
      check("R1 mid-run reset drops entry", int'(iraw), 0);
      irs1 = 5'd27;
      idle(8);
   endtask

   task automatic t_stream(input logic [1:0] c);
      int ok = 0;
      for (int k = 0; k < 10; k++) begin
         set_op(1, c, 28, 29, 30, RW'(k + 1));
         #1;
         if (issue && !stall) ok++;
         @(negedge clk);
      end
      check($sformatf("R3 back-to-back class %0d", c), ok, 10);
      idle(10);
   endtask

   task automatic t_latency(input logic [1:0] c, input int exp);
      int n;
      set_op(1, c, 28, 29, 30, 5);
      #1;
      check("R2 producer issues", int'(issue), 1);
      @(negedge clk);
      set_op(1, 2'b00, 28, 5, 30, 6);
      #1;
      check("R12 stall on dependence", int'(stall), 1);
      count_stalls(n);
      check($sformatf("R2 R4 stall length class %0d", c), n, exp);
      @(negedge clk);
      idle(8);
   endtask

   task automatic t_raw_rs3;
      int n;
      set_op(1, 2'b00, 28, 29, 30, 8);
      @(negedge clk);
      set_op(1, 2'b00, 28, 29, 8, 9);
      count_stalls(n);
      check("R4 rs3 dependence on retiring entry", n, 1);
      @(negedge clk);
      idle(6);
   endtask

   task automatic t_waw;
      int n;
      set_op(1, 2'b10, 28, 29, 30, 9);
      @(negedge clk);
      set_op(1, 2'b00, 28, 29, 30, 9);
      count_stalls(n);
      check("R5 same destination", n, LAT_OT);
      @(negedge clk);
      idle(8);
   endtask

   task automatic t_clash;
      int n;
      set_op(1, 2'b01, 28, 29, 30, 10);
      @(negedge clk);
      op_valid = 1'b0;
      @(negedge clk);
      set_op(1, 2'b00, 28, 29, 30, 11);
      count_stalls(n);
      check("R6 single-cycle op collides with add/mul", n, 1);
      @(negedge clk);
      idle(8);
      set_op(1, 2'b10, 28, 29, 30, 12);
      @(negedge clk);
      op_valid = 1'b0;
      @(negedge clk);
      set_op(1, 2'b01, 28, 29, 30, 13);
      count_stalls(n);
      check("R6 add/mul collides with other class", n, 1);
      @(negedge clk);
      idle(8);
   endtask

   task automatic t_serial;
      int n;
      set_op(1, 2'b11, 28, 29, 30, 12);
      #1;
      check("R7 serial issues on empty board", int'(issue), 1);
      @(negedge clk);
      set_op(1, 2'b00, 28, 29, 30, 13);
      n = 0;
      for (int j = 0; j < 5; j++) begin
         #1;
         if (stall) n++;
         @(negedge clk);
      end
      check("R8 independent op held behind serial", n, 5);
      man_res = 1'b1;
      #1;
      check("R8 no issue in pulse cycle", int'(issue), 0);
      @(negedge clk);
      man_res = 1'b0;
      #1;
      check("R8 issue after pulse", int'(issue), 1);
      @(negedge clk);
      idle(6);
      set_op(1, 2'b01, 28, 29, 30, 14);
      @(negedge clk);
      set_op(1, 2'b11, 28, 29, 30, 15);
      count_stalls(n);
      check("R7 serial waits for empty board", n, LAT_AM);
      @(negedge clk);
      op_valid = 1'b0;
      @(negedge clk);
      man_res = 1'b1;
      @(negedge clk);
      man_res = 1'b0;
      idle(4);
   endtask

   task automatic t_full;
      logic [5:0] got;
      logic [RW-1:0] d = 1;
      for (int k = 0; k < 6; k++) begin
         set_op(1, 2'b10, 28, 29, 30, d);
         #1;
         got[k] = issue;
         if (issue) d = d + 1;
         @(negedge clk);
      end
      check("R3 four issues fill board", int'(got[3:0]), 15);
      check("R9 stall on full board", int'(got[4]), 0);
      check("R9 retiring slot reused", int'(got[5]), 1);
      idle(12);
   endtask

   task automatic t_flush;
      set_op(1, 2'b10, 28, 29, 30, 16);
      @(negedge clk);
      set_op(1, 2'b10, 28, 29, 30, 17);
      @(negedge clk);
      flush = 1'b1;
      set_op(1, 2'b00, 16, 29, 30, 18);
      #1;
      check("R10 no issue during flush", int'(issue), 0);
      @(negedge clk);
      flush = 1'b0;
      irs1 = 5'd17;
      #1;
      check("R10 dependent op issues after flush", int'(issue), 1);
      check("R10 int_raw cleared by flush", int'(iraw), 0);
      @(negedge clk);
      irs1 = 5'd27;
      idle(6);
   endtask

   task automatic t_int;
      set_op(1, 2'b10, 28, 29, 30, 7);
      @(negedge clk);                       // cycle A+1
      op_valid = 1'b0;
      irs1 = 5'd7;
      #1;
      check("R11 raw on int_rs1", int'(iraw), 1);
      check("R11 no waw", int'(iwaw), 0);
      @(negedge clk);                       // A+2
      irs1 = 5'd27; irs2 = 5'd7;
      #1;
      check("R11 raw on int_rs2", int'(iraw), 1);
      @(negedge clk);                       // A+3
      irs2 = 5'd27; ird = 5'd7;
      #1;
      check("R11 waw on int_rd", int'(iwaw), 1);
      check("R11 no raw", int'(iraw), 0);
      @(negedge clk);                       // A+4
      ird = 5'd1;
      #1;
      check("R11 unrelated int instruction", int'(iwaw | iraw), 0);
      @(negedge clk);                       // A+5, retiring
      @(negedge clk);                       // A+6
      irs1 = 5'd7; ird = 5'd7;
      #1;
      check("R11 flags clear after retirement", int'(iwaw | iraw), 0);
      irs1 = 5'd27; ird = 5'd27;
      idle(4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_stream(2'b00);
      t_stream(2'b01);
      t_latency(2'b00, 1);
      t_latency(2'b01, LAT_AM);
      t_latency(2'b10, LAT_OT);
      t_raw_rs3();
      t_waw();
      t_clash();
      t_serial();
      t_full();
      t_flush();
      t_int();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule